// File: doc/BRIEF.md
# Lockable Security Control Register Bank

This block is a 32-bit register bank that a configuration-security controller places on a simple word-wide bus. A control register holds the security fields: AES fuse select, AES enable, SEU enable, secure enable, and the debug and debug-port enables. A sticky lock register can freeze each group of these fields. Once a lock bit is set, writes to the control register leave the guarded field unchanged until the next reset.

A key register guards the whole register window. Writing the correct key turns on the partial-reconfiguration enable and all three AES enable bits. Writing any other value clears those bits and closes the window: reads then return zero and writes are ignored until reset. The bank also holds an interrupt status register, an interrupt mask register and a level interrupt output. Event pulses set status bits, and software clears them by writing ones. A separate error output flags an AES enable field whose three bits are not all equal.

Registers are addressed by word index: 0 control, 1 lock, 2 key, 3 interrupt status, 4 interrupt mask. Every other index reads as zero and ignores writes.

Top module: `secure_ctrl_regs`

## Requirements
- R1: After reset, control reads 0x0C006000, lock reads 0, interrupt status reads 0x88020000, interrupt mask reads 0xF8F7FFFF, and irq is low.
- R2: The lock register keeps only bits 4:0. Each write ORs the written value into those bits, so a lock bit that is set stays set until reset. Bits 31:5 read 0.
- R3: On a control write, a field whose lock bit is set keeps its value. The guards are: lock bit 4 guards control bit 12, bit 3 guards bits 11:9, bit 2 guards bit 8, bit 1 guards bit 7, and bit 0 guards bits 6:0. Unlocked writable fields take the written data.
- R4: The writable control bits are 27, 26, 24 and 15:0, except bits 14:13. Bits 14:13 always read 1. Bit 31 and every other bit ignore writes and read 0.
- R5: Writing the key 0x757BDF0D to index 2 sets control bit 27 and bits 11:9, whatever the lock state, and the window stays open.
- R6: Writing any other value to index 2 clears control bit 27 and bits 11:9 and closes the window. Until reset, reads then return 0 and bus writes have no effect.
- R7: Writing a 1 to a bit of interrupt status clears that bit. Bits 26:24 and 19 are reserved: they read 0 and cannot be set.
- R8: An event input bit that is high for a cycle sets the matching non-reserved status bit. If an event and a write-1 clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R9: irq is high exactly when some status bit is set whose mask bit is 0. The mask register keeps its non-reserved bits.
- R10: aes_err is high while the control AES enable field (bits 11:9) is neither 000 nor 111.
- R11: A read of an unmapped word index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of a read request |
| evt_set | input | 32 | Event pulses that set interrupt status bits |
| irq | output | 1 | Level interrupt |
| aes_err | output | 1 | Inconsistent AES enable field |

## Verification
The bench uses the default parameters: a 3-bit word index and the standard key. With a 3-bit index, the unmapped indices 5 to 7 can be reached, and the five lock bits can be stacked one at a time over a single control register. Because the key is a parameter, the correct and the wrong unlock paths can both be driven in one run, with a reset in between.

// File: rtl/secure_ctrl_regs.sv
module secure_ctrl_regs #(
  parameter int          ADDR_W     = 3,
  parameter logic [31:0] UNLOCK_KEY = 32'h757BDF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       evt_set,
  output logic              irq,
  output logic              aes_err
);
  localparam logic [ADDR_W-1:0] IX_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IX_LOCK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_KEY  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IX_STS  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IX_MSK  = ADDR_W'(4);

  localparam logic [31:0] CTRL_WMASK = 32'h0D00_9FFF;
  localparam logic [31:0] CTRL_FIXED = 32'h0000_6000;
  localparam logic [31:0] CTRL_RST   = 32'h0C00_6000;
  localparam logic [31:0] PR_AES     = 32'h0800_0E00;
  localparam logic [31:0] STS_RSVD   = 32'h0708_0000;
  localparam logic [31:0] STS_RST    = 32'h8802_0000;
  localparam int          LOCK_W     = 5;

  logic [31:0]       ctrl_q, sts_q, msk_q;
  logic [LOCK_W-1:0] lock_q;
  logic              open_q;
  logic [31:0]       guard;
  logic              wr;

  assign wr = req && we && open_q;

  always_comb begin
    guard        = '0;
    guard[12]    = lock_q[4];
    guard[11:9]  = {3{lock_q[3]}};
    guard[8]     = lock_q[2];
    guard[7]     = lock_q[1];
    guard[6:0]   = {7{lock_q[0]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      lock_q <= '0;
      sts_q  <= STS_RST;
      msk_q  <= ~STS_RSVD;
      open_q <= 1'b1;
    end else begin
      if (wr && addr == IX_CTRL)
        ctrl_q <= (wdata & CTRL_WMASK & ~guard) | (ctrl_q & guard) | CTRL_FIXED;
      if (wr && addr == IX_LOCK)
        lock_q <= lock_q | wdata[LOCK_W-1:0];
      if (wr && addr == IX_KEY) begin
        if (wdata == UNLOCK_KEY) begin
          ctrl_q <= ctrl_q | PR_AES;
        end else begin
          ctrl_q <= ctrl_q & ~PR_AES;
          open_q <= 1'b0;
        end
      end
      if (wr && addr == IX_MSK)
        msk_q <= wdata & ~STS_RSVD;
      sts_q <= ((sts_q & ~((wr && addr == IX_STS) ? wdata : 32'h0)) | evt_set) & ~STS_RSVD;
    end
  end

  always_comb begin
    rdata = '0;
    if (req && !we && open_q) begin
      case (addr)
        IX_CTRL: rdata = ctrl_q;
        IX_LOCK: rdata = {{(32-LOCK_W){1'b0}}, lock_q};
        IX_STS:  rdata = sts_q;
        IX_MSK:  rdata = msk_q;
        default: rdata = '0;
      endcase
    end
  end

  assign irq     = |(sts_q & ~msk_q);
  assign aes_err = (ctrl_q[11:9] != 3'b000) && (ctrl_q[11:9] != 3'b111);
endmodule

module secure_ctrl_regs_chk #(
  parameter int          ADDR_W     = 3,
  parameter logic [31:0] UNLOCK_KEY = 32'h757BDF0D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       sts_q,
  input logic [4:0]        lock_q,
  input logic              open_q,
  input logic              aes_err
);
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_q) & ~lock_q) == 5'b0));

  a_r3_sec_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[1] |=> ctrl_q[7] == $past(ctrl_q[7]));

  a_r3_seu_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[2] |=> ctrl_q[8] == $past(ctrl_q[8]));

  a_r5_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && open_q && addr == ADDR_W'(2) && wdata == UNLOCK_KEY)
      |=> (open_q && ctrl_q[27] && !aes_err));

  a_r6_stays_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |=> !open_q);

  a_r6_closed_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> rdata == 32'h0);

  a_r7_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & 32'h0708_0000) == 32'h0);

  a_r4_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[31] && ctrl_q[14:13] == 2'b11);
endmodule

bind secure_ctrl_regs secure_ctrl_regs_chk #(.ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ctrl_q(ctrl_q), .sts_q(sts_q), .lock_q(lock_q),
  .open_q(open_q), .aes_err(aes_err)
);

// File: tb/secure_ctrl_regs_test.sv
module secure_ctrl_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, evt_set = '0;
  logic [31:0] rdata;
  logic        irq, aes_err;
  int          n_run = 0, n_fail = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  secure_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_set(evt_set), .irq(irq), .aes_err(aes_err));

  // {is_read, addr, data, expected}
  localparam logic [67:0] VEC [14] = '{
    {1'b1, 3'd0, 32'h0, 32'h0C00_6000},   // R1 control
    {1'b1, 3'd3, 32'h0, 32'h8802_0000},   // R1 status
    {1'b1, 3'd4, 32'h0, 32'hF8F7_FFFF},   // R1 mask
    {1'b1, 3'd1, 32'h0, 32'h0},           // R1 lock
    {1'b0, 3'd0, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 3'd0, 32'h0, 32'h0D00_FFFF},   // R4 writable bits
    {1'b0, 3'd0, 32'h0, 32'h0},
    {1'b0, 3'd1, 32'h2, 32'h0},
    {1'b0, 3'd1, 32'h1, 32'h0},
    {1'b0, 3'd1, 32'hFFFF_FFE0, 32'h0},
    {1'b1, 3'd1, 32'h0, 32'h3},           // R2 OR, upper bits dropped
    {1'b0, 3'd0, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 3'd0, 32'h0, 32'h0D00_FF00},   // R3 bits 7:0 frozen
    {1'b1, 3'd5, 32'h0, 32'h0}            // R11 unmapped
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][67]) begin
        rd(VEC[i][66:64], got);
        check($sformatf("R1-R4/R11 vec %0d", i), got, VEC[i][31:0]);
      end else
        wr(VEC[i][66:64], VEC[i][63:32]);
    end
    wr(1, 32'h1C);
    rd(1, got);  check("R2 all locks", got, 32'h1F);
    wr(0, 32'h0);
    rd(0, got);  check("R3 bits 12:7 frozen", got, 32'h0000_7F00);

    do_reset();
    wr(0, 32'h0000_0200);
    check("R10 aes 001", {31'b0, aes_err}, 32'h1);
    wr(0, 32'h0000_0E00);
    check("R10 aes 111", {31'b0, aes_err}, 32'h0);
    wr(0, 32'h0);
    wr(1, 32'h8);
    wr(2, 32'h757B_DF0D);
    rd(0, got);  check("R5 key sets bits", got, 32'h0800_6E00);
    check("R5 aes_err", {31'b0, aes_err}, 32'h0);

    @(negedge clk); evt_set = 32'h0000_1000;
    @(negedge clk); evt_set = 0;
    rd(3, got);  check("R8 event sets", got, 32'h8802_1000);
    check("R9 masked irq", {31'b0, irq}, 32'h0);
    wr(4, 32'h0);
    check("R9 unmasked irq", {31'b0, irq}, 32'h1);
    wr(3, 32'hFFFF_FFFF);
    rd(3, got);  check("R7 w1c", got, 32'h0);
    check("R9 irq after clear", {31'b0, irq}, 32'h0);
    @(negedge clk); evt_set = 32'hFFFF_FFFF;
    @(negedge clk); evt_set = 0;
    rd(3, got);  check("R7 reserved", got, 32'hF8F7_FFFF);
    wr(3, 32'hFFFF_FFFF);
    @(negedge clk); req = 1; we = 1; addr = 3; wdata = 32'h20; evt_set = 32'h20;
    @(negedge clk); req = 0; we = 0; evt_set = 0;
    rd(3, got);  check("R8 set beats clear", got, 32'h20);

    wr(2, 32'h0000_1234);
    rd(0, got);  check("R6 closed read", got, 32'h0);
    wr(4, 32'hFFFF_FFFF);
    check("R6 write ignored (irq)", {31'b0, irq}, 32'h1);
    wr(2, 32'h757B_DF0D);
    rd(3, got);  check("R6 still closed", got, 32'h0);
    do_reset();
    rd(0, got);  check("R6 reopen after reset", got, 32'h0C00_6000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule